// File: doc/BRIEF.md
# Multi-dimensional element index remapper

This block converts a plain loop count into a reordered element index. It treats a vector of up to 127 elements as a 1D, 2D or 3D array and walks that array with three nested counters. It emits one index per accepted transfer. A 32-bit shape word sets the size of each axis, which axis is innermost, which axes run backwards, which axis is dropped from the index, and a small constant that is added to every result. A shape word of all zeros turns the remapping off, so the block counts linearly.

A controller writes the shape word and the step count to `cfg_shape` and `cfg_len`, then pulses `start`. The indices leave on a valid/ready stream. `out_valid` stays high from the cycle after the launch until the final index has been accepted. A transfer takes place on every rising edge at which `out_valid` and `out_ready` are both high. While `out_ready` is low, the index and the last flag hold their values and no step is taken. One index can leave per cycle. There is no buffering, so there is no extra latency under back-pressure.

Top module: `mdim_index_remap`

## Requirements
- R1: After reset, `out_valid` is low.
- R2: A `start` pulse while idle with a nonzero `cfg_len` captures `cfg_shape` and `cfg_len`, and `out_valid` is high at the next cycle. A `start` pulse while busy, or with `cfg_len` of zero, is ignored.
- R3: While `out_valid` is high and `out_ready` is low, `out_idx` and `out_last` hold their values and the sequence does not advance.
- R4: `out_last` is high exactly on step `cfg_len`-1. Once that step is accepted, `out_valid` is low at the next cycle.
- R5: The shape fields sit at these positions: x size-1 in bits 5:0, y size-1 in bits 11:6, z size-1 in bits 17:12, nesting order in bits 20:18, reverse flags in bits 23:21 (bit 21 for x, bit 22 for y, bit 23 for z), offset in bits 27:24, drop select in bits 29:28, and bits 31:30 held at 00. A size field of 0 means one element.
- R6: The nesting order code, listed innermost first, selects: 0 → x,y,z; 1 → x,z,y; 2 → y,x,z; 3 → y,z,x; 4 → z,x,y; 5 → z,y,x. The innermost axis steps every transfer and carries into the next axis when it wraps.
- R7: An axis whose reverse flag is set produces coordinates from its size-1 down to 0. Otherwise it produces 0 upward.
- R8: The index is the sum over the kept axes of coordinate × stride. The stride of x is 1, the stride of y is the x size (or 1 if x is dropped), and the stride of z is the stride of y × the y size (or × 1 if y is dropped). Drop select 1 drops x, 2 drops y, 3 drops z, and 0 drops none.
- R9: The 4-bit offset is added to every index, and the result is taken modulo 128.
- R10: A shape word of all zeros makes `out_idx` equal to the step number.
- R11: A step count larger than the array size keeps stepping: the outermost axis wraps to its start, and the sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, used only while idle |
| cfg_shape | input | 32 | Shape word, layout per R5 |
| cfg_len | input | 7 | Number of indices to produce (1 to 127) |
| out_valid | output | 1 | Index on `out_idx` is valid |
| out_ready | input | 1 | Consumer accepts the current index |
| out_idx | output | 7 | Remapped element index |
| out_last | output | 1 | Current index is the final one |

## Verification
The assertions rely on three assumptions about the inputs:
- the nesting order code is 0 to 5;
- bits 31:30 of the shape word are zero;
- `out_ready` is a clean level sampled at the clock edge.

The bench keeps to these in every case. Its sweep covers four small shapes whose products stay under 128. Each of these shapes is run with all six orders, all eight reverse patterns and all four drop selects. `out_ready` is withheld pseudo-randomly, so that the holding rule is exercised throughout the sweep. Directed runs use `cfg_len` at its maximum, an axis at its 64-element limit, and offset wrap past 127.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int SZW = 6;

  localparam logic [1:0] AX_X = 2'd0;
  localparam logic [1:0] AX_Y = 2'd1;
  localparam logic [1:0] AX_Z = 2'd2;

  typedef struct packed {
    logic [1:0]     mode;
    logic [1:0]     drop;
    logic [3:0]     offset;
    logic [2:0]     rev;
    logic [2:0]     order;
    logic [SZW-1:0] zm;
    logic [SZW-1:0] ym;
    logic [SZW-1:0] xm;
  } shape_t;

  // Axis driven at nesting level lvl (0 = innermost) for an order code.
  function automatic logic [1:0] level_axis(input logic [2:0] order, input int lvl);
    logic [5:0] seq;
    case (order)
      3'd1:    seq = {AX_Y, AX_Z, AX_X};
      3'd2:    seq = {AX_Z, AX_X, AX_Y};
      3'd3:    seq = {AX_X, AX_Z, AX_Y};
      3'd4:    seq = {AX_Y, AX_X, AX_Z};
      3'd5:    seq = {AX_X, AX_Y, AX_Z};
      default: seq = {AX_Z, AX_Y, AX_X};
    endcase
    return seq[lvl*2 +: 2];
  endfunction

endpackage

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         at_lim
);

  assign at_lim = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= at_lim ? '0 : cnt + 1'b1;
  end

  // R5: a counter never exceeds its size field
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

endmodule

// File: rtl/remap_index_compose.sv
module remap_index_compose
  import remap_pkg::*;
#(
  parameter int IDXW = 7,
  parameter int VLW  = 7
) (
  input  logic [2:0][SZW-1:0] cnt,
  input  logic [2:0][SZW-1:0] lim,
  input  logic [2:0]          rev,
  input  logic [1:0]          drop,
  input  logic [3:0]          offset,
  input  logic                bypass,
  input  logic [VLW-1:0]      step,
  output logic [IDXW-1:0]     idx
);

  localparam int WW = 3*SZW + 3;

  logic [2:0][SZW-1:0] coord;
  logic [2:0]          keep;
  logic [2:0][WW-1:0]  sz;
  logic [2:0][WW-1:0]  stride;
  logic [WW-1:0]       sum;

  for (genvar a = 0; a < 3; a++) begin : g_axis
    assign coord[a] = rev[a] ? lim[a] - cnt[a] : cnt[a];
    assign keep[a]  = (drop != 2'(a + 1));
    assign sz[a]    = WW'(lim[a]) + WW'(1);
  end

  always_comb begin
    stride[0] = WW'(1);
    stride[1] = keep[0] ? sz[0] : WW'(1);
    stride[2] = WW'(stride[1] * (keep[1] ? sz[1] : WW'(1)));
    sum = WW'(offset);
    for (int a = 0; a < 3; a++)
      if (keep[a]) sum = WW'(sum + WW'(coord[a]) * stride[a]);
  end

  assign idx = bypass ? IDXW'(step) : IDXW'(sum);

endmodule

// File: rtl/mdim_index_remap.sv
module mdim_index_remap
  import remap_pkg::*;
#(
  parameter int IDXW = 7,
  parameter int VLW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     cfg_shape,
  input  logic [VLW-1:0]  cfg_len,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IDXW-1:0] out_idx,
  output logic            out_last
);

  shape_t              shp_q;
  logic [VLW-1:0]      len_q;
  logic [VLW-1:0]      step_q;
  logic                busy_q;
  logic                load, adv, bypass;
  logic [2:0][SZW-1:0] lim, cnt;
  logic [2:0]          at_lim, axis_inc, lvl_inc;
  logic [1:0]          lvl_ax [3];

  assign load      = start && !busy_q && (cfg_len != '0);
  assign adv       = busy_q && out_ready;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (step_q == len_q - 1'b1);
  assign bypass    = (shp_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
      shp_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      step_q <= '0;
      len_q  <= cfg_len;
      shp_q  <= shape_t'(cfg_shape);
    end else if (adv) begin
      if (out_last) busy_q <= 1'b0;
      step_q <= step_q + 1'b1;
    end
  end

  assign lim[0] = shp_q.xm;
  assign lim[1] = shp_q.ym;
  assign lim[2] = shp_q.zm;

  // carry chain follows the nesting order: innermost steps on each transfer
  always_comb begin
    for (int k = 0; k < 3; k++) lvl_ax[k] = level_axis(shp_q.order, k);
    lvl_inc[0] = adv;
    lvl_inc[1] = lvl_inc[0] && at_lim[lvl_ax[0]];
    lvl_inc[2] = lvl_inc[1] && at_lim[lvl_ax[1]];
    axis_inc   = '0;
    for (int k = 0; k < 3; k++) axis_inc[lvl_ax[k]] = lvl_inc[k];
  end

  for (genvar a = 0; a < 3; a++) begin : g_ctr
    remap_axis_ctr #(.W(SZW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (load),
      .inc    (axis_inc[a]),
      .lim    (lim[a]),
      .cnt    (cnt[a]),
      .at_lim (at_lim[a])
    );
  end

  remap_index_compose #(.IDXW(IDXW), .VLW(VLW)) u_compose (
    .cnt    (cnt),
    .lim    (lim),
    .rev    (shp_q.rev),
    .drop   (shp_q.drop),
    .offset (shp_q.offset),
    .bypass (bypass),
    .step   (step_q),
    .idx    (out_idx)
  );

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !out_valid && cfg_len != '0) |=> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_last)));

  p_idle_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  p_linear_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && bypass) |=> (out_idx == IDXW'($past(out_idx) + 1'b1)));

endmodule

// File: tb/mdim_index_remap_tb.sv
module mdim_index_remap_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_shape = '0;
  logic [6:0]  cfg_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [6:0]  out_idx;
  logic        out_last;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdim_index_remap u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_shape(cfg_shape),
    .cfg_len(cfg_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_last(out_last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R4 act=%0d exp=<%0d cycles", cyc, 180000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int xm, int ym, int zm, int ord, int rv, int off, int dr);
    logic [31:0] w;
    w = {2'b00, 2'(dr), 4'(off), 3'(rv), 3'(ord), 6'(zm), 6'(ym), 6'(xm)};
    return w;
  endfunction

  // expected index from the requirements (R5..R11)
  function automatic int model(logic [31:0] sh, int s);
    int sz[3], d[3], c[3], ord[3], str[3], r, sum;
    bit keep[3];
    if (sh == 0) return s % 128;
    sz[0] = int'(sh[5:0]) + 1; sz[1] = int'(sh[11:6]) + 1; sz[2] = int'(sh[17:12]) + 1;
    case (sh[20:18])
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    r = s;
    for (int k = 0; k < 3; k++) begin
      d[ord[k]] = r % sz[ord[k]];
      r = r / sz[ord[k]];
    end
    for (int a = 0; a < 3; a++) begin
      c[a] = sh[21 + a] ? sz[a] - 1 - d[a] : d[a];
      keep[a] = (int'(sh[29:28]) != a + 1);
    end
    str[0] = 1;
    str[1] = keep[0] ? sz[0] : 1;
    str[2] = str[1] * (keep[1] ? sz[1] : 1);
    sum = int'(sh[27:24]);
    for (int a = 0; a < 3; a++) if (keep[a]) sum += c[a] * str[a];
    return sum % 128;
  endfunction

  task automatic run(input logic [31:0] sh, input int len, input string tag, input bit rnd);
    int  s;
    bit  r;
    @(negedge clk);
    cfg_shape = sh; cfg_len = 7'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = 0;
    while (s < len) begin
      check(out_valid == 1'b1, "R2 valid during run", int'(out_valid), 1);
      check(int'(out_idx) == model(sh, s), tag, int'(out_idx), model(sh, s));
      check(out_last == (s == len - 1), "R4 last flag", int'(out_last), int'(s == len - 1));
      r = rnd ? (($urandom % 4) != 0) : 1'b1;
      out_ready = r;
      @(negedge clk);
      if (r) s++;
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R4 idle after last", int'(out_valid), 0);
  endtask

  initial begin
    int xs[4], ys[4], zs[4];
    xs = '{2, 1, 0, 3}; ys = '{1, 2, 1, 0}; zs = '{1, 0, 2, 1};

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    // R2: zero length ignored
    cfg_shape = mk(3, 0, 0, 0, 0, 0, 0); cfg_len = 7'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 zero length ignored", int'(out_valid), 0);

    // R2 and R3: start while busy is ignored; held output stays put
    cfg_shape = mk(3, 0, 0, 0, 0, 0, 0); cfg_len = 7'd4; start = 1'b1;
    @(negedge clk);
    cfg_shape = mk(1, 1, 0, 0, 7, 5, 0); cfg_len = 7'd9;
    @(negedge clk); start = 1'b0;
    check(int'(out_idx) == 0, "R3 held idx", int'(out_idx), 0);
    check(out_valid == 1'b1, "R3 held valid", int'(out_valid), 1);
    for (int s = 0; s < 4; s++) begin
      check(int'(out_idx) == s, "R2 busy start ignored", int'(out_idx), s);
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R2 original length kept", int'(out_valid), 0);

    // R10 bypass, full length
    run(32'h0, 127, "R10 bypass linear", 1'b1);
    // R5 field limits on each axis
    run(mk(63, 0, 0, 0, 0, 0, 0), 64, "R5 x field 64 elements", 1'b0);
    run(mk(0, 9, 0, 0, 0, 0, 0), 10, "R5 y field", 1'b1);
    run(mk(0, 0, 11, 0, 4, 0, 0), 12, "R5 z field", 1'b1);
    // R8 repeat and modulo patterns
    run(mk(2, 1, 0, 0, 0, 0, 1), 6, "R8 drop x repeats", 1'b0);
    run(mk(2, 1, 0, 0, 0, 0, 2), 6, "R8 drop y modulo", 1'b0);
    // R9 offset with wrap past 127
    run(mk(39, 2, 0, 0, 0, 15, 0), 120, "R9 offset wrap", 1'b1);
    // R11 length beyond array size
    run(mk(2, 1, 0, 2, 1, 3, 0), 15, "R11 outer wrap", 1'b1);

    // R6 R7 R8 R9 sweep
    for (int g = 0; g < 4; g++)
      for (int o = 0; o < 6; o++)
        for (int v = 0; v < 8; v++)
          for (int d = 0; d < 4; d++)
            run(mk(xs[g], ys[g], zs[g], o, v, (g * 5 + v) % 16, d),
                (xs[g] + 1) * (ys[g] + 1) * (zs[g] + 1),
                "R6/R7/R8/R9 sweep idx", 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule